// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Register Command Engine

This block sits behind the two-wire bus front end of a digitally controlled potentiometer. The front end tells it when a frame addressed to the device opens and whether that frame is a read or a write, hands it each received byte, asks it for read bytes, and reports the end of the frame. From these events the engine decodes a command byte. It then operates on a 10-bit volatile wiper register, whose value selects one of 1024 taps, and on four 10-bit data registers that stand in for nonvolatile storage. It drives the wiper code to the analog array. It also drives a busy flag that the front end uses to refuse the device address while a store is in progress.

Commands are either four bytes long (address, command, two data bytes), carrying a register value, or two bytes long (address, command), moving a value between the wiper and a data register. Changes are committed only at the end of the frame. A change to a data register starts a store. The store lasts a programmable number of clock cycles, and the engine ignores the bus for that time. A low write-protect input blocks every data register change. Reset recalls data register 0 into the wiper.

The controller has nine states. `S_RECALL` is entered by reset and copies data register 0 into the wiper. Its only transition goes to `S_IDLE` on the next clock. From any state except `S_RECALL` and `S_STORE`, a frame-open event moves to `S_CMD`, which waits for the command byte. From `S_CMD` a received byte leads to one of four states:
- `S_SEND` for the two read commands.
- `S_DATA_HI` for the two write commands.
- `S_ARMED` for the two transfers.
- `S_REJECT` for a bad command.

`S_DATA_HI` moves on a byte to `S_DATA_LO`, and `S_DATA_LO` moves on a byte to `S_ARMED`. A frame-end event in `S_ARMED` commits the pending command. It then moves to `S_STORE` when a data register was written, or to `S_IDLE` otherwise. A frame-end event in any other frame state returns to `S_IDLE` without a change. `S_STORE` returns to `S_IDLE` when the store timer expires.

Top module: `pot_cmd_engine`

## Requirements
- R1: While reset is applied, busy is 0. On the first clock after reset is released, the wiper code takes the contents of data register 0, so a value stored there before reset appears on the wiper code.
- R2: Command byte format: bits 7:5 are the opcode, bit 4 must be 0, bits 3:2 are the register pointer (0 to 3), bits 1:0 must be 0. A command byte with a nonzero reserved bit, or an opcode/direction pair not listed in R4 to R8, is answered with a negative acknowledge. Later bytes of that frame are also refused, and the frame end changes no register.
- R3: Every byte received in an open frame is answered by a one-cycle ack strobe in the following cycle. Ack good is 1 for an accepted command byte and for the two data bytes of a write, and 0 for any other byte, including bytes after a complete write.
- R4: Write direction with opcode 101 writes the wiper. The first data byte carries value bits 9:8 in its bits 1:0, and its upper six bits are ignored. The second data byte carries bits 7:0. The wiper code takes the value in the cycle after the frame end, with no busy period. Codes 0x000 and 0x3FF are both accepted.
- R5: Read direction with opcode 100 reads the wiper. After the command byte, the read byte is {6'b0, bits 9:8}. After a next-byte request, it is bits 7:0.
- R6: Write direction with opcode 110 writes the pointed data register at the frame end. Read direction with opcode 101 returns that register in the R5 byte order.
- R7: Read direction with opcode 110 copies the pointed data register into the wiper in the cycle after the frame end, without a busy period.
- R8: Write direction with opcode 111 copies the wiper into the pointed data register at the frame end and starts a store.
- R9: A data register change raises busy in the cycle after the frame end and holds it for exactly STORE_CYCLES cycles. While busy, frame events and bytes are ignored: no ack strobe, no register change.
- R10: When the write-protect input is low at the frame end, R6 writes and R8 copies leave the data register unchanged and raise no busy. Wiper writes still take effect.
- R11: A frame that ends before both data bytes of a write have arrived changes no register and raises no busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; causes wiper recall |
| bus_start | input | 1 | One-cycle pulse: a frame addressed to this device opened |
| bus_rw | input | 1 | Direction bit of the opening frame, 1 = read, sampled with bus_start |
| rx_valid | input | 1 | One-cycle pulse: rx_byte holds a byte received from the master |
| rx_byte | input | 8 | Received byte |
| tx_next | input | 1 | One-cycle pulse: the high read byte was sent, present the low one |
| bus_stop | input | 1 | One-cycle pulse: the frame ended |
| wp_n | input | 1 | Write protect, low blocks data register changes |
| ack_strobe | output | 1 | Pulses in the cycle after each byte handled in a frame |
| ack_good | output | 1 | Valid with ack_strobe: 1 acknowledge, 0 refuse |
| tx_byte | output | 8 | Byte to send for a read command |
| wiper_code | output | 10 | Tap select for the resistor array |
| busy | output | 1 | A data register store is in progress |

## Verification
A wrong pending operation or register pointer shows in the cycle after the frame end. The wiper code takes a wrong value, or a later read of a data register returns the wrong word. A wrong controller state shows sooner, as a wrong ack good on the very next byte, or as a missing or misplaced busy rise right after the frame end. A store timer that is off by one shows as a busy period of the wrong length, which the bench counts cycle by cycle. Ignored traffic during a store shows as a stray ack strobe. Nothing that touches the registers during that traffic is visible until the store ends.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

    localparam int PTR_W    = 2;
    localparam int NUM_REGS = 1 << PTR_W;

    typedef enum logic [2:0] {
        OP_BAD,
        OP_RD_WIPER,
        OP_WR_WIPER,
        OP_RD_REG,
        OP_WR_REG,
        OP_REG_TO_WIPER,
        OP_WIPER_TO_REG
    } op_e;

    typedef enum logic [3:0] {
        S_RECALL,
        S_IDLE,
        S_CMD,
        S_DATA_HI,
        S_DATA_LO,
        S_ARMED,
        S_SEND,
        S_REJECT,
        S_STORE
    } state_e;

endpackage

// File: rtl/pot_cmd_decode.sv
module pot_cmd_decode
    import pot_cmd_pkg::*;
(
    input  logic             rw,
    input  logic [7:0]       cmd,
    output op_e              op,
    output logic [PTR_W-1:0] ptr
);

    logic reserved_ok;

    always_comb begin
        reserved_ok = (cmd[4] == 1'b0) && (cmd[1:0] == 2'b00);
        ptr         = cmd[3:2];
        op          = OP_BAD;
        if (reserved_ok) begin
            case ({rw, cmd[7:5]})
                4'b1100: op = OP_RD_WIPER;
                4'b0101: op = OP_WR_WIPER;
                4'b1101: op = OP_RD_REG;
                4'b0110: op = OP_WR_REG;
                4'b1110: op = OP_REG_TO_WIPER;
                4'b0111: op = OP_WIPER_TO_REG;
                default: op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/pot_store_timer.sv
module pot_store_timer #(
    parameter int STORE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);

    localparam int CNT_W = (STORE_CYCLES < 2) ? 1 : $clog2(STORE_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STORE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pot_reg_file.sv
module pot_reg_file #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pot_cmd_engine.sv
module pot_cmd_engine
    import pot_cmd_pkg::*;
#(
    parameter int WIPER_W      = 10,
    parameter int STORE_CYCLES = 1_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_start,
    input  logic               bus_rw,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               tx_next,
    input  logic               bus_stop,
    input  logic               wp_n,
    output logic               ack_strobe,
    output logic               ack_good,
    output logic [7:0]         tx_byte,
    output logic [WIPER_W-1:0] wiper_code,
    output logic               busy
);

    localparam int HI_W = WIPER_W - 8;

    state_e             st_q, st_d;
    op_e                op_q, dec_op;
    logic [PTR_W-1:0]   ptr_q, dec_ptr, rd_addr;
    logic [WIPER_W-1:0] buf_q, wiper_q, rd_q, rd_data, wr_data;
    logic               rw_q, hi_q, ack_stb_q, ack_ok_q;
    logic               frame_live, stop_only, store_go, wiper_go, tmr_done;
    logic [15:0]        rd_ext;

    pot_cmd_decode u_dec (
        .rw  (rw_q),
        .cmd (rx_byte),
        .op  (dec_op),
        .ptr (dec_ptr)
    );

    assign rd_addr = (st_q == S_CMD)    ? dec_ptr :
                     (st_q == S_RECALL) ? '0      : ptr_q;
    assign wr_data = (op_q == OP_WR_REG) ? buf_q : wiper_q;

    pot_reg_file #(.WIDTH(WIPER_W), .DEPTH(NUM_REGS)) u_regs (
        .clk   (clk),
        .we    (store_go),
        .waddr (ptr_q),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    pot_store_timer #(.STORE_CYCLES(STORE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (store_go),
        .done  (tmr_done)
    );

    assign frame_live = (st_q != S_RECALL) && (st_q != S_STORE);
    assign stop_only  = bus_stop && !bus_start && (st_q == S_ARMED);
    assign store_go   = stop_only && wp_n &&
                        ((op_q == OP_WR_REG) || (op_q == OP_WIPER_TO_REG));
    assign wiper_go   = stop_only &&
                        ((op_q == OP_WR_WIPER) || (op_q == OP_REG_TO_WIPER));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_RECALL: st_d = S_IDLE;
            S_STORE:  if (tmr_done) st_d = S_IDLE;
            default: begin
                if (bus_start) begin
                    st_d = S_CMD;
                end else if (bus_stop) begin
                    st_d = store_go ? S_STORE : S_IDLE;
                end else if (rx_valid) begin
                    case (st_q)
                        S_CMD: begin
                            case (dec_op)
                                OP_BAD:                   st_d = S_REJECT;
                                OP_RD_WIPER, OP_RD_REG:   st_d = S_SEND;
                                OP_WR_WIPER, OP_WR_REG:   st_d = S_DATA_HI;
                                default:                  st_d = S_ARMED;
                            endcase
                        end
                        S_DATA_HI: st_d = S_DATA_LO;
                        S_DATA_LO: st_d = S_ARMED;
                        default:   st_d = st_q;
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_RECALL;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_BAD;
            ptr_q     <= '0;
            buf_q     <= '0;
            rw_q      <= 1'b0;
            wiper_q   <= '0;
            rd_q      <= '0;
            hi_q      <= 1'b1;
            ack_stb_q <= 1'b0;
            ack_ok_q  <= 1'b0;
        end else begin
            ack_stb_q <= 1'b0;
            ack_ok_q  <= 1'b0;
            if (st_q == S_RECALL) begin
                wiper_q <= rd_data;
            end
            if (wiper_go) begin
                wiper_q <= (op_q == OP_WR_WIPER) ? buf_q : rd_data;
            end
            if (frame_live && bus_start) begin
                rw_q <= bus_rw;
                op_q <= OP_BAD;
            end else if (frame_live && !bus_stop && rx_valid && st_q != S_IDLE) begin
                ack_stb_q <= 1'b1;
                case (st_q)
                    S_CMD: begin
                        ack_ok_q <= (dec_op != OP_BAD);
                        op_q     <= dec_op;
                        ptr_q    <= dec_ptr;
                        rd_q     <= (dec_op == OP_RD_WIPER) ? wiper_q : rd_data;
                        hi_q     <= 1'b1;
                    end
                    S_DATA_HI: begin
                        ack_ok_q               <= 1'b1;
                        buf_q[WIPER_W-1:8]     <= rx_byte[HI_W-1:0];
                    end
                    S_DATA_LO: begin
                        ack_ok_q   <= 1'b1;
                        buf_q[7:0] <= rx_byte;
                    end
                    default: ack_ok_q <= 1'b0;
                endcase
            end
            if (tx_next) begin
                hi_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        rd_ext     = 16'(rd_q);
        tx_byte    = hi_q ? rd_ext[15:8] : rd_ext[7:0];
        wiper_code = wiper_q;
        busy       = (st_q == S_STORE);
        ack_strobe = ack_stb_q;
        ack_good   = ack_ok_q;
    end

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |-> $past(rx_valid)); // R3

    AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_stop && st_q != S_RECALL) |=> $stable(wiper_code)); // R4

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop)); // R9

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !ack_strobe); // R9

    AST_PROTECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n)); // R10

endmodule

// File: tb/pot_cmd_engine_bench.sv
module pot_cmd_engine_bench;

    localparam int ST = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_rw = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_next = 1'b0, bus_stop = 1'b0, wp_n = 1'b1;
    logic       ack_strobe, ack_good, busy;
    logic [7:0] tx_byte;
    logic [9:0] wiper_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit expq[$];

    always #2.5 clk = ~clk;

    pot_cmd_engine #(.WIPER_W(10), .STORE_CYCLES(ST)) u_pot_cmd_engine (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rw(bus_rw),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_next(tx_next),
        .bus_stop(bus_stop), .wp_n(wp_n), .ack_strobe(ack_strobe),
        .ack_good(ack_good), .tx_byte(tx_byte), .wiper_code(wiper_code),
        .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each ack against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && ack_strobe) begin
            n_chk++;
            if (expq.size() == 0) begin
                n_fail++;
                $display("FAIL R3/R9 unexpected ack actual=%0h expected=none", ack_good);
            end else begin
                bit e;
                e = expq.pop_front();
                if (ack_good != e) begin
                    n_fail++;
                    $display("FAIL R2/R3 ack_good actual=%0h expected=%0h", ack_good, e);
                end
            end
        end
    end

    task automatic open_frame(input logic rw);
        bus_rw = rw; bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input bit ok);
        expq.push_back(ok);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic raw_byte(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic close_frame();
        bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic wr_word(input logic [7:0] cmd, input logic [9:0] v);
        open_frame(1'b0);
        put_byte(cmd, 1'b1);
        put_byte({6'b101101, v[9:8]}, 1'b1);
        put_byte(v[7:0], 1'b1);
        close_frame();
    endtask

    task automatic rd_word(input logic [7:0] cmd, input logic [9:0] v, input string tag);
        open_frame(1'b1);
        put_byte(cmd, 1'b1);
        chk({tag, " high byte"}, tx_byte, {6'b0, v[9:8]});
        tx_next = 1'b1; @(negedge clk); tx_next = 1'b0;
        chk({tag, " low byte"}, tx_byte, v[7:0]);
        close_frame();
    endtask

    task automatic xfer(input logic rw, input logic [7:0] cmd);
        open_frame(rw);
        put_byte(cmd, 1'b1);
        close_frame();
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 busy after reset", busy, 0);

        // R4 wiper write
        wr_word(8'hA0, 10'h2A5);
        chk("R4 wiper write", wiper_code, 10'h2A5);
        chk("R4 no busy", busy, 0);

        // R3 byte after full write refused, write still commits
        open_frame(1'b0);
        put_byte(8'hA0, 1'b1); put_byte(8'h01, 1'b1); put_byte(8'h55, 1'b1);
        put_byte(8'h77, 1'b0);
        close_frame();
        chk("R3 write with extra byte", wiper_code, 10'h155);

        // R5 wiper read
        rd_word(8'h80, 10'h155, "R5 wiper read");

        // R6 / R9 data register write and store length
        wr_word(8'hC4, 10'h3FF);
        wait_idle(c);
        chk("R9 busy length", c, ST);
        rd_word(8'hA4, 10'h3FF, "R6 reg1 read");
        wr_word(8'hC8, 10'h0F0);
        wait_idle(c);
        rd_word(8'hA8, 10'h0F0, "R6 reg2 read");

        // R7 register to wiper
        xfer(1'b1, 8'hC4);
        chk("R7 copy to wiper", wiper_code, 10'h3FF);
        chk("R7 no busy", busy, 0);

        // R4 boundary, R8 wiper to register, R9 ignored traffic
        wr_word(8'hA0, 10'h000);
        chk("R4 zero code", wiper_code, 10'h000);
        xfer(1'b0, 8'hE8);
        chk("R8 busy raised", busy, 1);
        open_frame(1'b0);
        raw_byte(8'hA0); raw_byte(8'h02); raw_byte(8'h22);
        close_frame();
        wait_idle(c);
        chk("R9 ignored frame", wiper_code, 10'h000);
        rd_word(8'hA8, 10'h000, "R8 reg2 read");

        // R10 write protect
        wp_n = 1'b0;
        wr_word(8'hC4, 10'h155);
        chk("R10 no busy on write", busy, 0);
        xfer(1'b0, 8'hE4);
        chk("R10 no busy on copy", busy, 0);
        rd_word(8'hA4, 10'h3FF, "R10 reg1 kept");
        wr_word(8'hA0, 10'h03C);
        chk("R10 wiper still writable", wiper_code, 10'h03C);
        wp_n = 1'b1;

        // R2 bad command bytes
        open_frame(1'b0);
        put_byte(8'hB0, 1'b0); put_byte(8'h03, 1'b0); put_byte(8'hFF, 1'b0);
        close_frame();
        chk("R2 reserved bit", wiper_code, 10'h03C);
        xfer_bad: begin
            open_frame(1'b0); put_byte(8'h80, 1'b0); close_frame();
            open_frame(1'b1); put_byte(8'hE0, 1'b0); close_frame();
            open_frame(1'b0); put_byte(8'hA1, 1'b0); close_frame();
        end
        chk("R2 no change", wiper_code, 10'h03C);
        chk("R2 no busy", busy, 0);

        // R11 truncated writes
        open_frame(1'b0); put_byte(8'hA0, 1'b1); put_byte(8'h03, 1'b1); close_frame();
        chk("R11 wiper kept", wiper_code, 10'h03C);
        open_frame(1'b0); put_byte(8'hCC, 1'b1); put_byte(8'h01, 1'b1); close_frame();
        chk("R11 no busy", busy, 0);

        // R1 recall of register 0
        wr_word(8'hC0, 10'h1C3);
        wait_idle(c);
        wr_word(8'hA0, 10'h001);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 recall", wiper_code, 10'h1C3);
        chk("R1 busy", busy, 0);

        chk("R3 pending acks", expq.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule